// File: doc/BRIEF.md
# Per-Core Idle State Controller

This block follows the idle state of one processor core. Decoded idle requests take the running core into a halt state, a monitor-wait halt, a C2 idle state or a C3 idle state. C3 is reached only after the level-1 cache has been written back. A set of wake events brings the core back to the running state. Which events count depends on the current state and on the active-low stop-clock input.

From the running state or either halt state, the stop-clock input parks the core in a stop-grant state. Releasing stop-clock returns the core to the state it came from. Snoops that arrive in halt, monitor-wait, C2 or stop-grant are served in a one-cycle snoopable sub-state. A core in C3 ignores snoops and stays asleep. Instruction decoding, the cache itself and coordination across cores are handled outside the block.

Top module: `idle_ctl`

## Requirements
- R1: `state_o` uses the encoding running=0, halt=1, monitor-wait=2, C2=3, C3=4, stop-grant=5, flush-pending=6, snoop=7. While `rst_n` is low, `state_o` is 0, `flush_req_o` is 0, `clk_en_o` is 1 and `snoop_ack_o` is 0.
- R2: In the running state with stop-clock released, idle requests select the next state one edge later. `halt_req_i` selects halt. A monitor-wait with hint 0 selects monitor-wait. `lvl2_rd_i` or a monitor-wait with hint 1 selects C2. When several requests are active together, the deepest target wins.
- R3: In the running state, `lvl3_rd_i` or a monitor-wait with hint 2 or 3 moves the core to flush-pending. `flush_req_o` is high in the first flush-pending cycle only. The core moves to C3 on the edge that samples `flush_done_i` high.
- R4: `clk_en_o` is low exactly while the state is C3.
- R5: The halt state returns to running when any bit of `brk_lines_i` is high. A monitor event alone does not wake it.
- R6: The monitor-wait state returns to running on any break line or on `mon_evt_i`.
- R7: C2 and C3 return to running only when a break line or monitor event is present while `stpclk_n_i` is high. With stop-clock asserted, they hold.
- R8: Asserting stop-clock (`stpclk_n_i` low) in running, halt or monitor-wait moves the core to stop-grant. This takes priority over requests and wakes in the same cycle. Releasing stop-clock returns the core to the state it left. Break lines are ignored in stop-grant. Stop-clock changes have no effect in C2 or C3.
- R9: A snoop in halt, monitor-wait, C2 or stop-grant moves the core to snoop for exactly one cycle, with `snoop_ack_o` high, and then back to the prior state. A snoop in running, flush-pending or C3 changes nothing and is not acknowledged.
- R10: `sg_ack_req_o` is high exactly when stop-clock is asserted and the state is stop-grant, C2 or C3.
- R11: `core_reset_i` returns the core to running on the next edge from any state, ahead of every other input. In flush-pending, this abandons the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | Halt instruction decoded |
| mwait_req_i | input | 1 | Monitor-wait instruction decoded |
| mwait_hint_i | input | 2 | Monitor-wait depth hint |
| lvl2_rd_i | input | 1 | Level-2 idle read |
| lvl3_rd_i | input | 1 | Level-3 idle read |
| brk_lines_i | input | NUM_BRK | Halt-break event lines |
| core_reset_i | input | 1 | Core reset event |
| mon_evt_i | input | 1 | Armed monitor fired |
| stpclk_n_i | input | 1 | Stop-clock, active low |
| snoop_req_i | input | 1 | Snoop strobe |
| flush_done_i | input | 1 | L1 write-back complete pulse |
| state_o | output | 3 | Current state code |
| flush_req_o | output | 1 | L1 write-back request pulse |
| clk_en_o | output | 1 | Core clock enable |
| snoop_ack_o | output | 1 | Snoop served |
| sg_ack_req_o | output | 1 | Stop-grant acknowledge request |

## Verification
Every state is visible on `state_o`, so a wrong transition shows at the port one edge after the input that caused it. A stale return register for stop-grant or the snoop sub-state shows up only later, when the core leaves that state: the core lands on the wrong code in the cycle after stop-clock release, or after the snoop cycle. A wrongly gated clock or a repeated flush pulse shows on `clk_en_o` and `flush_req_o` in the same cycle as the faulty state.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int ST_W   = 3;
  localparam int HINT_W = 2;

  typedef enum logic [ST_W-1:0] {
    IS_RUN     = 3'd0,
    IS_HALT    = 3'd1,
    IS_MWAIT   = 3'd2,
    IS_C2      = 3'd3,
    IS_C3      = 3'd4,
    IS_STOPGNT = 3'd5,
    IS_FLUSH   = 3'd6,
    IS_SNOOP   = 3'd7
  } idle_st_t;

  // depth rank used to arbitrate simultaneous idle requests
  function automatic logic [1:0] depth_rank(idle_st_t s);
    case (s)
      IS_FLUSH: depth_rank = 2'd3;
      IS_C2:    depth_rank = 2'd2;
      IS_MWAIT: depth_rank = 2'd1;
      default:  depth_rank = 2'd0;
    endcase
  endfunction

  function automatic idle_st_t hint_target(logic [HINT_W-1:0] h);
    case (h)
      2'd0:    hint_target = IS_MWAIT;
      2'd1:    hint_target = IS_C2;
      default: hint_target = IS_FLUSH;
    endcase
  endfunction

  function automatic logic is_snoopable(idle_st_t s);
    is_snoopable = (s == IS_HALT) || (s == IS_MWAIT) ||
                   (s == IS_C2)   || (s == IS_STOPGNT);
  endfunction

  function automatic logic stop_clock_deaf(idle_st_t s);
    stop_clock_deaf = (s == IS_C2) || (s == IS_C3);
  endfunction

  function automatic logic sg_visible(idle_st_t s);
    sg_visible = (s == IS_STOPGNT) || stop_clock_deaf(s);
  endfunction
endpackage

// File: rtl/idle_req_dec.sv
module idle_req_dec
  import idle_pkg::*;
(
  input  logic              halt_req,
  input  logic              mwait_req,
  input  logic [HINT_W-1:0] mwait_hint,
  input  logic              lvl2_rd,
  input  logic              lvl3_rd,
  output logic              entry_vld,
  output idle_st_t          entry_tgt
);
  localparam int NUM_SRC = 4;

  logic     src_vld [NUM_SRC];
  idle_st_t src_tgt [NUM_SRC];

  always_comb begin
    src_vld[0] = halt_req;   src_tgt[0] = IS_HALT;
    src_vld[1] = mwait_req;  src_tgt[1] = hint_target(mwait_hint);
    src_vld[2] = lvl2_rd;    src_tgt[2] = IS_C2;
    src_vld[3] = lvl3_rd;    src_tgt[3] = IS_FLUSH;
  end

  // deepest requested target wins
  always_comb begin
    entry_vld = 1'b0;
    entry_tgt = IS_RUN;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_vld[i] && (!entry_vld || depth_rank(src_tgt[i]) > depth_rank(entry_tgt))) begin
        entry_vld = 1'b1;
        entry_tgt = src_tgt[i];
      end
    end
  end
endmodule

// File: rtl/idle_wake.sv
module idle_wake
  import idle_pkg::*;
#(
  parameter int NUM_BRK = 7
) (
  input  logic [NUM_BRK-1:0] brk_lines,
  input  logic               mon_evt,
  input  logic               stpclk_n,
  input  idle_st_t           st,
  output logic               halt_brk,
  output logic               core_brk,
  output logic               wake_now
);
  assign halt_brk = |brk_lines;
  assign core_brk = (halt_brk | mon_evt) & stpclk_n;

  always_comb begin
    case (st)
      IS_HALT:      wake_now = halt_brk;
      IS_MWAIT:     wake_now = halt_brk | mon_evt;
      IS_C2, IS_C3: wake_now = core_brk;
      default:      wake_now = 1'b0;
    endcase
  end
endmodule

// File: rtl/idle_seq.sv
module idle_seq
  import idle_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     core_reset,
  input  logic     stpclk_n,
  input  logic     snoop_req,
  input  logic     flush_done,
  input  logic     entry_vld,
  input  idle_st_t entry_tgt,
  input  logic     wake_now,
  output idle_st_t st_q,
  output logic     flush_req_q,
  output logic     clk_en_q
);
  idle_st_t st_nxt, sg_ret_q, sg_ret_nxt, snp_ret_q, snp_ret_nxt;
  logic     stp_on;

  assign stp_on = ~stpclk_n;

  always_comb begin
    st_nxt      = st_q;
    sg_ret_nxt  = sg_ret_q;
    snp_ret_nxt = snp_ret_q;
    if (core_reset) begin
      st_nxt = IS_RUN;
    end else begin
      case (st_q)
        IS_RUN: begin
          if (stp_on) begin
            st_nxt     = IS_STOPGNT;
            sg_ret_nxt = IS_RUN;
          end else if (entry_vld) begin
            st_nxt = entry_tgt;
          end
        end
        IS_HALT, IS_MWAIT: begin
          if (stp_on) begin
            st_nxt     = IS_STOPGNT;
            sg_ret_nxt = st_q;
          end else if (wake_now) begin
            st_nxt = IS_RUN;
          end else if (snoop_req) begin
            st_nxt      = IS_SNOOP;
            snp_ret_nxt = st_q;
          end
        end
        IS_C2: begin
          if (wake_now) begin
            st_nxt = IS_RUN;
          end else if (snoop_req && is_snoopable(st_q)) begin
            st_nxt      = IS_SNOOP;
            snp_ret_nxt = IS_C2;
          end
        end
        IS_FLUSH: begin
          if (flush_done) st_nxt = IS_C3;
        end
        IS_C3: begin
          if (wake_now) st_nxt = IS_RUN;
        end
        IS_STOPGNT: begin
          if (!stp_on) begin
            st_nxt = sg_ret_q;
          end else if (snoop_req) begin
            st_nxt      = IS_SNOOP;
            snp_ret_nxt = IS_STOPGNT;
          end
        end
        default: st_nxt = snp_ret_q;  // IS_SNOOP lasts one cycle
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= IS_RUN;
      sg_ret_q    <= IS_RUN;
      snp_ret_q   <= IS_RUN;
      flush_req_q <= 1'b0;
      clk_en_q    <= 1'b1;
    end else begin
      st_q        <= st_nxt;
      sg_ret_q    <= sg_ret_nxt;
      snp_ret_q   <= snp_ret_nxt;
      flush_req_q <= (st_nxt == IS_FLUSH) && (st_q != IS_FLUSH);
      clk_en_q    <= (st_nxt != IS_C3);
    end
  end
endmodule

// File: rtl/idle_ctl.sv
module idle_ctl
  import idle_pkg::*;
#(
  parameter int NUM_BRK = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req_i,
  input  logic               mwait_req_i,
  input  logic [HINT_W-1:0]  mwait_hint_i,
  input  logic               lvl2_rd_i,
  input  logic               lvl3_rd_i,
  input  logic [NUM_BRK-1:0] brk_lines_i,
  input  logic               core_reset_i,
  input  logic               mon_evt_i,
  input  logic               stpclk_n_i,
  input  logic               snoop_req_i,
  input  logic               flush_done_i,
  output logic [ST_W-1:0]    state_o,
  output logic               flush_req_o,
  output logic               clk_en_o,
  output logic               snoop_ack_o,
  output logic               sg_ack_req_o
);
  idle_st_t st_q;
  idle_st_t entry_tgt;
  logic     entry_vld;
  logic     halt_brk;
  logic     core_brk;
  logic     wake_now;

  idle_req_dec u_dec (
    .halt_req   (halt_req_i),
    .mwait_req  (mwait_req_i),
    .mwait_hint (mwait_hint_i),
    .lvl2_rd    (lvl2_rd_i),
    .lvl3_rd    (lvl3_rd_i),
    .entry_vld  (entry_vld),
    .entry_tgt  (entry_tgt)
  );

  idle_wake #(.NUM_BRK(NUM_BRK)) u_wake (
    .brk_lines (brk_lines_i),
    .mon_evt   (mon_evt_i),
    .stpclk_n  (stpclk_n_i),
    .st        (st_q),
    .halt_brk  (halt_brk),
    .core_brk  (core_brk),
    .wake_now  (wake_now)
  );

  idle_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_reset  (core_reset_i),
    .stpclk_n    (stpclk_n_i),
    .snoop_req   (snoop_req_i),
    .flush_done  (flush_done_i),
    .entry_vld   (entry_vld),
    .entry_tgt   (entry_tgt),
    .wake_now    (wake_now),
    .st_q        (st_q),
    .flush_req_q (flush_req_o),
    .clk_en_q    (clk_en_o)
  );

  assign state_o      = st_q;
  assign snoop_ack_o  = (st_q == IS_SNOOP);
  assign sg_ack_req_o = ~stpclk_n_i & sg_visible(st_q);
endmodule

// File: rtl/idle_ctl_chk.sv
module idle_ctl_chk
  import idle_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input idle_st_t st,
  input logic     flush_req,
  input logic     flush_done,
  input logic     clk_en,
  input logic     snoop_req,
  input logic     snoop_ack,
  input logic     stpclk_n,
  input logic     sg_ack,
  input logic     core_reset,
  input logic     mon_evt,
  input logic     halt_brk,
  input logic     core_brk
);
  a_r3_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  a_r3_flush_owner: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> st == IS_FLUSH);

  a_r3_c3_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IS_FLUSH && flush_done && !core_reset) |=> st == IS_C3);

  a_r4_gate_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> (st == IS_C3 && $past(st) == IS_FLUSH));

  a_r5_halt_ignores_mon: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IS_HALT && mon_evt && !halt_brk && stpclk_n && !snoop_req && !core_reset)
      |=> st == IS_HALT);

  a_r7_c2_holds_under_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IS_C2 && !stpclk_n && !snoop_req && !core_reset) |=> st == IS_C2);

  a_r7_c3_wake_needs_break: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IS_C3 && !core_brk && !core_reset) |=> st == IS_C3);

  a_r9_snoop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_ack |=> !snoop_ack);

  a_r9_c3_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IS_C3 && snoop_req) |=> !snoop_ack);

  a_r10_sg_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    sg_ack |-> !stpclk_n);

  a_r11_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> st == IS_RUN);
endmodule

bind idle_ctl idle_ctl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .st         (st_q),
  .flush_req  (flush_req_o),
  .flush_done (flush_done_i),
  .clk_en     (clk_en_o),
  .snoop_req  (snoop_req_i),
  .snoop_ack  (snoop_ack_o),
  .stpclk_n   (stpclk_n_i),
  .sg_ack     (sg_ack_req_o),
  .core_reset (core_reset_i),
  .mon_evt    (mon_evt_i),
  .halt_brk   (halt_brk),
  .core_brk   (core_brk)
);

// File: tb/idle_ctl_tb_top.sv
`timescale 1ns/100ps
module idle_ctl_tb_top;
  localparam int NB = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          halt_req, mwait_req, lvl2_rd, lvl3_rd;
  logic [1:0]    mwait_hint;
  logic [NB-1:0] brk;
  logic          core_reset, mon_evt, stpclk_n, snoop_req, flush_done;
  logic [2:0]    state;
  logic          flush_req, clk_en, snoop_ack, sg_ack;

  typedef struct packed {
    logic [2:0] st;
    logic       fl;
    logic       ce;
    logic       ack;
    logic       sg;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  always #2.5 clk = ~clk;

  idle_ctl #(.NUM_BRK(NB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .halt_req_i(halt_req), .mwait_req_i(mwait_req), .mwait_hint_i(mwait_hint),
    .lvl2_rd_i(lvl2_rd), .lvl3_rd_i(lvl3_rd), .brk_lines_i(brk),
    .core_reset_i(core_reset), .mon_evt_i(mon_evt), .stpclk_n_i(stpclk_n),
    .snoop_req_i(snoop_req), .flush_done_i(flush_done),
    .state_o(state), .flush_req_o(flush_req), .clk_en_o(clk_en),
    .snoop_ack_o(snoop_ack), .sg_ack_req_o(sg_ack)
  );

  task automatic clr_pulses();
    halt_req = 0; mwait_req = 0; mwait_hint = 0; lvl2_rd = 0; lvl3_rd = 0;
    brk = '0; core_reset = 0; mon_evt = 0; snoop_req = 0; flush_done = 0;
  endtask

  // driver: pushes the expected outcome of the coming edge, then advances
  task automatic cyc(input logic [2:0] st, input logic fl, input string tag);
    exp_t e;
    e.st  = st;
    e.fl  = fl;
    e.ce  = (st != 3'd4);                                     // R4
    e.ack = (st == 3'd7);                                     // R9
    e.sg  = !stpclk_n && (st == 3'd5 || st == 3'd3 || st == 3'd4); // R10
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    clr_pulses();
  endtask

  // monitor: compares after each edge once the registers have settled
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {state, flush_req, clk_en, snoop_ack, sg_ack};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual st=%0d fl=%b ce=%b ack=%b sg=%b expected st=%0d fl=%b ce=%b ack=%b sg=%b",
                 t, a.st, a.fl, a.ce, a.ack, a.sg, e.st, e.fl, e.ce, e.ack, e.sg);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stpclk_n = 1; clr_pulses();
    repeat (3) @(negedge clk);
    n_chk++;
    if ({state, flush_req, clk_en, snoop_ack} !== {3'd0, 1'b0, 1'b1, 1'b0}) begin
      n_fail++;
      $display("FAIL R1 reset: actual st=%0d fl=%b ce=%b ack=%b expected st=0 fl=0 ce=1 ack=0",
               state, flush_req, clk_en, snoop_ack);
    end
    rst_n = 1;
    @(negedge clk);

    // halt entry and wake rules
    halt_req = 1;                 cyc(3'd1, 0, "R2 halt entry");
                                  cyc(3'd1, 0, "R2 halt holds");
    mon_evt = 1;                  cyc(3'd1, 0, "R5 monitor alone ignored in halt");
    brk = 7'b0001000;             cyc(3'd0, 0, "R5 break wakes halt");

    // priority and monitor-wait wakes
    halt_req = 1; mwait_req = 1;  cyc(3'd2, 0, "R2 monitor-wait beats halt");
    mon_evt = 1;                  cyc(3'd0, 0, "R6 monitor wakes mwait");
    mwait_req = 1;                cyc(3'd2, 0, "R2 hint 0 monitor-wait");
    brk = 7'b0000001;             cyc(3'd0, 0, "R6 break wakes mwait");

    // C2: snoop, stop-clock deafness, gated wake
    halt_req = 1; lvl2_rd = 1;    cyc(3'd3, 0, "R2 level-2 beats halt");
    snoop_req = 1;                cyc(3'd7, 0, "R9 snoop sub-state from C2");
                                  cyc(3'd3, 0, "R9 back to C2");
    stpclk_n = 0;                 cyc(3'd3, 0, "R8 stop-clock ignored in C2, R10 sg req");
    brk = 7'b1000000;             cyc(3'd3, 0, "R7 break under stop-clock holds C2");
    stpclk_n = 1;                 cyc(3'd3, 0, "R8 release ignored in C2");
    mon_evt = 1;                  cyc(3'd0, 0, "R7 monitor wakes C2");

    // C3 via flush handshake
    lvl3_rd = 1; lvl2_rd = 1;     cyc(3'd6, 1, "R3 flush request pulse");
                                  cyc(3'd6, 0, "R3 flush pulse single");
                                  cyc(3'd6, 0, "R3 waits for done");
    flush_done = 1;               cyc(3'd4, 0, "R3 R4 enter C3 gated");
    snoop_req = 1;                cyc(3'd4, 0, "R9 snoop ignored in C3");
    stpclk_n = 0;                 cyc(3'd4, 0, "R8 R10 stop-clock in C3");
    brk = 7'b0000010;             cyc(3'd4, 0, "R7 break under stop-clock holds C3");
    stpclk_n = 1; brk = 7'b0000010; cyc(3'd0, 0, "R7 R4 break wakes C3");

    // hint encodings and reset
    mwait_req = 1; mwait_hint = 3; cyc(3'd6, 1, "R3 hint 3 selects C3 path");
    core_reset = 1; flush_done = 1; cyc(3'd0, 0, "R11 reset abandons flush");
    mwait_req = 1; mwait_hint = 1; cyc(3'd3, 0, "R2 hint 1 selects C2");
    core_reset = 1;               cyc(3'd0, 0, "R11 reset from C2");
    mwait_req = 1; mwait_hint = 2; cyc(3'd6, 1, "R3 hint 2 selects C3 path");
    flush_done = 1;               cyc(3'd4, 0, "R3 done enters C3");
    core_reset = 1;               cyc(3'd0, 0, "R11 reset from C3");
    snoop_req = 1;                cyc(3'd0, 0, "R9 snoop ignored when running");

    // stop-grant from halt
    halt_req = 1;                 cyc(3'd1, 0, "R2 halt again");
    stpclk_n = 0; brk = 7'b0000100; cyc(3'd5, 0, "R8 stop-clock beats break in halt");
    brk = 7'b0010000;             cyc(3'd5, 0, "R8 break ignored in stop-grant");
    snoop_req = 1;                cyc(3'd7, 0, "R9 snoop from stop-grant");
                                  cyc(3'd5, 0, "R9 back to stop-grant");
    stpclk_n = 1;                 cyc(3'd1, 0, "R8 release returns to halt");
    brk = 7'b0100000;             cyc(3'd0, 0, "R5 break wakes halt after stop");

    // stop-grant from running
    stpclk_n = 0; halt_req = 1;   cyc(3'd5, 0, "R8 stop-clock beats halt request");
    stpclk_n = 1;                 cyc(3'd0, 0, "R8 release returns to running");
    mwait_req = 1;                cyc(3'd2, 0, "R2 mwait before stop");
    stpclk_n = 0;                 cyc(3'd5, 0, "R8 stop from mwait");
    core_reset = 1;               cyc(3'd0, 0, "R11 reset from stop-grant");
    stpclk_n = 1;                 cyc(3'd0, 0, "R11 stays running");

    @(posedge clk); #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule